// File: doc/BRIEF.md
# General-Purpose Pin Bank Controller

This block manages a bank of pins (32 by default). For each pin it chooses one of two owners for the output path. One owner is the block itself, which then supplies the output level and the drive enable from its own registers. The other owner is an on-chip peripheral, whose output level and drive enable are passed straight to the pad. The raw pad input always goes to the peripheral side unchanged.

Inside the block, every pad input passes through a two-stage synchroniser. A per-pin deglitch filter can be switched in after that. Any change in the resulting level is recorded in a sticky event register, which clears when it is read. The interrupt output is raised while an event bit is set and its mask bit is on.

Software reaches the block through a simple APB-style register port inside a 16 KB window. Every configuration register that is written often appears at three addresses:

- a write-one-to-set address,
- a write-one-to-clear address,
- a value address.

This lets single bits change without a read-modify-write. The per-pin deglitch filter is a four-state machine:

- FS_LOW: the level is settled low.
- FS_RISE_WAIT: one high sample has been seen while low. A second high sample moves to FS_HIGH. A low sample returns to FS_LOW.
- FS_HIGH: the level is settled high.
- FS_FALL_WAIT: one low sample has been seen while high. A second low sample moves to FS_LOW. A high sample returns to FS_HIGH.

The transition FS_LOW to FS_RISE_WAIT is taken on a high sample. The transition FS_HIGH to FS_FALL_WAIT is taken on a low sample. The filtered level is high in FS_HIGH and FS_FALL_WAIT.

Top module: `pio_bank`

## Requirements
- R1: After reset every pin is owned by the block, pad_oe and pad_out are all zero, irq is low, the ownership register reads all ones, and the drive-enable, output, filter-enable and mask registers read zero.
- R2: The register groups are ownership (base 0x00), drive enable (0x10), output data (0x20), filter enable (0x30) and interrupt mask (0x40). A write to base+0x0 sets every bit whose write-data bit is one and leaves the bits written with zero unchanged.
- R3: A write to base+0x4 of a group clears every bit whose write-data bit is one and leaves the bits written with zero unchanged.
- R4: A read of base+0x8 returns the stored group value. The pin level is at 0x50 and the event status at 0x54. A read of a set or clear address, or of any other offset, returns zero.
- R5: A pin whose ownership bit is 1 drives pad_out and pad_oe from the output-data and drive-enable registers. A pin whose ownership bit is 0 drives them from per_out and per_oe. per_in always equals pad_in.
- R6: With the filter off, a pad_in change reaches the pin level after two clock edges. The matching event bit is set at the third edge.
- R7: With a pin's filter on, a new level passes only after it has been seen on two consecutive edges at the synchroniser output, two edges later than unfiltered. A one-cycle pulse is removed entirely.
- R8: Every change of a pin's (filtered) level sets that pin's event status bit, whether or not the pin is masked. Set bits stay set until read.
- R9: A read of the event status address returns the bits and clears them all.
- R10: irq is high exactly when some event status bit has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a register transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (14) | Byte offset in the 16 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| pad_in | input | NPINS (32) | Levels from the pads |
| pad_out | output | NPINS (32) | Levels to the pads |
| pad_oe | output | NPINS (32) | Pad drive enables |
| per_out | input | NPINS (32) | Output levels from the peripherals |
| per_oe | input | NPINS (32) | Drive enables from the peripherals |
| per_in | output | NPINS (32) | Pad levels forwarded to the peripherals |
| irq | output | 1 | Interrupt request |

## Verification
Random set and clear writes with random data, each followed by a value read, separate one-to-set behaviour from a plain store. They also show whether zero bits are left alone. Random ownership, output and peripheral vectors exercise the owner selection, so a swapped or missing mux leg shows up at the pads.

Directed pin edges are observed cycle by cycle on irq. With the filter off and on, this tells the two-edge synchroniser latency apart from the extra filter latency. A one-cycle pulse and a two-cycle pulse, each with the filter on and off, separate a working deglitcher from a pass-through. An event on a masked pin separates status capture from interrupt gating.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        FS_LOW,
        FS_RISE_WAIT,
        FS_HIGH,
        FS_FALL_WAIT
    } flt_state_e;

    localparam int NGRP       = 5;
    localparam int GRP_STRIDE = 16;
    localparam int OFF_SET    = 0;
    localparam int OFF_CLR    = 4;
    localparam int OFF_VAL    = 8;

    localparam int GRP_OWN    = 0;
    localparam int GRP_OE     = 1;
    localparam int GRP_OUT    = 2;
    localparam int GRP_FLT    = 3;
    localparam int GRP_MASK   = 4;

    localparam int OFF_LEVEL  = 'h50;
    localparam int OFF_STAT   = 'h54;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/pio_glitch.sv
module pio_glitch
    import pio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    flt_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_LOW:       if (din) st_d = FS_RISE_WAIT;
            FS_RISE_WAIT: st_d = din ? FS_HIGH : FS_LOW;
            FS_HIGH:      if (!din) st_d = FS_FALL_WAIT;
            FS_FALL_WAIT: st_d = din ? FS_HIGH : FS_LOW;
            default:      st_d = FS_LOW;
        endcase
    end

    always_comb begin
        dout = (st_q == FS_HIGH) || (st_q == FS_FALL_WAIT);
    end
endmodule

// File: rtl/pio_setclr.sv
module pio_setclr #(
    parameter int             W   = 32,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= RST;
        else if (set_stb) q <= q | wbits;
        else if (clr_stb) q <= q & ~wbits;
    end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  per_out,
    input  logic [NPINS-1:0]  per_oe,
    output logic [NPINS-1:0]  per_in,
    output logic              irq
);
    localparam int DW = 32;

    logic             wr_acc, rd_acc, rd_stat;
    logic [NPINS-1:0] grp_q [NGRP];
    logic [NPINS-1:0] own_q, oe_q, out_q, flt_q, imask_q;
    logic [NPINS-1:0] sync_lvl, fsm_lvl, filt_lvl, filt_prev, istat;

    assign wr_acc  = psel && penable && pwrite;
    assign rd_acc  = psel && penable && !pwrite;
    assign rd_stat = rd_acc && (paddr == ADDR_W'(OFF_STAT));

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic set_stb, clr_stb;
        assign set_stb = wr_acc && (paddr == ADDR_W'(g*GRP_STRIDE + OFF_SET));
        assign clr_stb = wr_acc && (paddr == ADDR_W'(g*GRP_STRIDE + OFF_CLR));
        pio_setclr #(
            .W   (NPINS),
            .RST ({NPINS{1'(g == GRP_OWN)}})
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_stb),
            .clr_stb (clr_stb),
            .wbits   (pwdata[NPINS-1:0]),
            .q       (grp_q[g])
        );
    end

    assign own_q   = grp_q[GRP_OWN];
    assign oe_q    = grp_q[GRP_OE];
    assign out_q   = grp_q[GRP_OUT];
    assign flt_q   = grp_q[GRP_FLT];
    assign imask_q = grp_q[GRP_MASK];

    assign pad_out = (own_q & out_q) | (~own_q & per_out);
    assign pad_oe  = (own_q & oe_q)  | (~own_q & per_oe);
    assign per_in  = pad_in;

    pio_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_lvl)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_flt
        pio_glitch u_glitch (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sync_lvl[i]),
            .dout  (fsm_lvl[i])
        );
    end

    assign filt_lvl = (flt_q & fsm_lvl) | (~flt_q & sync_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_prev <= '0;
            istat     <= '0;
        end else begin
            filt_prev <= filt_lvl;
            istat     <= (rd_stat ? '0 : istat) | (filt_lvl ^ filt_prev);
        end
    end

    assign irq = |(istat & imask_q);

    always_comb begin
        prdata = '0;
        if (psel) begin
            for (int g = 0; g < NGRP; g++) begin
                if (paddr == ADDR_W'(g*GRP_STRIDE + OFF_VAL)) prdata = DW'(grp_q[g]);
            end
            if (paddr == ADDR_W'(OFF_LEVEL)) prdata = DW'(filt_lvl);
            if (paddr == ADDR_W'(OFF_STAT))  prdata = DW'(istat);
        end
    end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
    import pio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [NPINS-1:0]  out_q,
    input logic [NPINS-1:0]  flt_q,
    input logic [NPINS-1:0]  imask_q,
    input logic [NPINS-1:0]  sync_lvl,
    input logic [NPINS-1:0]  filt_lvl,
    input logic [NPINS-1:0]  istat,
    input logic              irq
);
    logic             acc, wr_set, wr_clr, rd_st;
    logic [NPINS-1:0] wd;

    assign acc    = psel && penable;
    assign wd     = pwdata[NPINS-1:0];
    assign wr_set = acc && pwrite && (paddr == ADDR_W'(GRP_OUT*GRP_STRIDE + OFF_SET));
    assign wr_clr = acc && pwrite && (paddr == ADDR_W'(GRP_OUT*GRP_STRIDE + OFF_CLR));
    assign rd_st  = acc && !pwrite && (paddr == ADDR_W'(OFF_STAT));

    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & $past(wd)) == $past(wd))); // R2
    AST_SET_ZEROS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & ~$past(wd)) == ($past(out_q) & ~$past(wd)))); // R2
    AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_q & $past(wd)) == '0)); // R3
    AST_CLR_ZEROS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_q & ~$past(wd)) == ($past(out_q) & ~$past(wd)))); // R3
    AST_FILTER_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (((filt_lvl ^ $past(filt_lvl)) & flt_q & $past(flt_q)
          & ~(($past(sync_lvl) & $past(sync_lvl, 2) & filt_lvl)
            | (~$past(sync_lvl) & ~$past(sync_lvl, 2) & ~filt_lvl))) == '0)); // R7
    AST_EVENT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((istat & ~$past(istat) & ~($past(filt_lvl) ^ $past(filt_lvl, 2))) == '0)); // R8
    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_st |=> ((istat & $past(istat)) == $past(istat))); // R8
    AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q == '0) |-> !irq); // R10
endmodule

bind pio_bank pio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .out_q    (out_q),
    .flt_q    (flt_q),
    .imask_q  (imask_q),
    .sync_lvl (sync_lvl),
    .filt_lvl (filt_lvl),
    .istat    (istat),
    .irq      (irq)
);

// File: tb/pio_bank_test.sv
module pio_bank_test;
    localparam int NP = 32;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          psel = 0, penable = 0, pwrite = 0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe, per_out = '0, per_oe = '0, per_in;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] model [5];

    pio_bank #(.NPINS(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
        .per_in(per_in), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = AW'(a); pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = AW'(a); penable = 0;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    function automatic logic [31:0] apply(logic [31:0] cur, bit clr, logic [31:0] d);
        return clr ? (cur & ~d) : (cur | d);
    endfunction

    function automatic logic [31:0] mux_exp(logic [31:0] own, logic [31:0] reg_v, logic [31:0] per_v);
        return (own & reg_v) | (~own & per_v);
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'hC0FFEE));
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 irq", 32'(irq), 0);
        model[0] = '1;
        for (int g = 1; g < 5; g++) model[g] = '0;
        for (int g = 0; g < 5; g++) begin
            rd(g*16 + 8, v);
            check($sformatf("R1 group %0d", g), v, model[g]);
        end

        // R4 write-only and unmapped addresses read zero
        rd('h00, v); check("R4 set address reads 0", v, 0);
        rd('h24, v); check("R4 clear address reads 0", v, 0);
        rd('h58, v); check("R4 unmapped 0x58", v, 0);
        rd('h3FFC, v); check("R4 unmapped top", v, 0);

        // R2 R3 random set/clear with value read-back (filter/mask groups kept quiet by pads at 0)
        for (int n = 0; n < 60; n++) begin
            int g = $urandom % 5;
            bit c = $urandom % 2;
            logic [31:0] d = $urandom;
            wr(g*16 + (c ? 4 : 0), d);
            model[g] = apply(model[g], c, d);
            rd(g*16 + 8, v);
            check(c ? "R3 clear" : "R2 set", v, model[g]);
        end
        // directed corners: zero data changes nothing, all ones
        wr('h20, 32'h0); rd('h28, v); check("R2 zero set keeps", v, model[2]);
        wr('h24, 32'h0); rd('h28, v); check("R3 zero clear keeps", v, model[2]);
        wr('h20, '1); model[2] = '1; rd('h28, v); check("R2 all ones", v, '1);
        wr('h24, 32'h0000_FFFF); model[2] = 32'hFFFF_0000; rd('h28, v); check("R3 low half", v, model[2]);

        // R5 owner selection
        for (int n = 0; n < 12; n++) begin
            logic [31:0] o = $urandom, e = $urandom, d = $urandom;
            wr('h04, '1); wr('h00, o);
            wr('h14, '1); wr('h10, e);
            wr('h24, '1); wr('h20, d);
            @(negedge clk);
            per_out = $urandom; per_oe = $urandom; pad_in = '0;
            #1;
            check("R5 pad_out", pad_out, mux_exp(o, d, per_out));
            check("R5 pad_oe", pad_oe, mux_exp(o, e, per_oe));
            check("R5 per_in", per_in, pad_in);
        end

        // quiet set-up for events
        wr('h00, '1); wr('h34, '1); wr('h44, '1);
        repeat (4) @(negedge clk);
        rd('h54, v);
        wr('h40, 32'h8);

        // R6 R8 R10 unfiltered rise on pin 3, cycle-exact on irq
        @(negedge clk); pad_in[3] = 1;
        @(negedge clk);
        @(negedge clk); check("R6 irq low after 2 edges", 32'(irq), 0);
        @(negedge clk); check("R6 R10 irq high after 3 edges", 32'(irq), 1);
        rd('h54, v); check("R8 status pin3", v, 32'h8);
        check("R9 irq drops after read", 32'(irq), 0);
        rd('h54, v); check("R9 status cleared", v, 0);
        rd('h50, v); check("R6 level", v, 32'h8);

        // R7 filtered fall on pin 3
        wr('h30, 32'h8);
        @(negedge clk); pad_in[3] = 0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); check("R7 irq low after 3 edges", 32'(irq), 0);
        @(negedge clk); check("R7 irq low after 4 edges", 32'(irq), 0);
        @(negedge clk); check("R7 irq high after 5 edges", 32'(irq), 1);
        rd('h54, v); check("R7 status filtered fall", v, 32'h8);
        rd('h50, v); check("R7 level low", v, 0);

        // R7 one-cycle glitch removed
        @(negedge clk); pad_in[3] = 1;
        @(negedge clk); pad_in[3] = 0;
        repeat (6) @(negedge clk);
        rd('h54, v); check("R7 glitch no event", v, 0);
        rd('h50, v); check("R7 glitch level", v, 0);
        check("R7 glitch irq", 32'(irq), 0);

        // R7 two-cycle pulse passes
        @(negedge clk); pad_in[3] = 1;
        @(negedge clk);
        @(negedge clk); pad_in[3] = 0;
        repeat (8) @(negedge clk);
        rd('h54, v); check("R7 two-cycle pulse event", v, 32'h8);

        // R8 R10 unfiltered one-cycle pulse on masked-off pin 5
        @(negedge clk); pad_in[5] = 1;
        @(negedge clk); pad_in[5] = 0;
        repeat (6) @(negedge clk);
        check("R10 masked pin no irq", 32'(irq), 0);
        rd('h54, v); check("R8 unfiltered pulse event", v, 32'h20);

        // R10 enabling mask on pending event raises irq
        @(negedge clk); pad_in[9] = 1;
        repeat (6) @(negedge clk);
        check("R10 pin9 unmasked -> no irq", 32'(irq), 0);
        wr('h40, 32'h200);
        @(negedge clk);
        check("R10 irq after mask set", 32'(irq), 1);
        wr('h44, 32'h200);
        @(negedge clk);
        check("R10 irq after mask clear", 32'(irq), 0);

        report();
    end
endmodule